// File: doc/BRIEF.md
# Tagged Word Memory with Pointer-Integrity Bits

The block is a word-addressed on-chip memory in which every 32-bit data word carries one hidden integrity tag. Software that owns the protection scheme sets a tag to mark a word that holds part of a protected pointer. Any ordinary modification of that word drops the tag in hardware, so a pointer that has been tampered with reads back as invalid. Only a privileged request that also carries the explicit tag-set command can raise a tag. The tag array sits beside the data array and not inside it, so no data byte lane can reach it.

A mode bit selects between tagged operation and plain memory behaviour. With the mode off, writes change data only, tag-set commands are ignored, tags read back as zero, and the stored tags are kept as they are. Every read returns the data word, its tag, and a group flag one clock after the request. The group flag is the AND of the tags of an aligned group of consecutive words, for example the four words of one wide pointer, so a consumer can check a whole pointer with a single read.

Top module: `tag_guard_mem`

## Requirements
- R1: A read request (reqValid=1, reqWrite=0) produces rdValid=1 on the next clock together with rdData, rdTag and rdGroupOk for that address. rdValid is 0 in every cycle that does not follow a read request.
- R2: After reset every data word is 0, every tag is 0, the tags mode is on and rdValid is 0.
- R3: With the mode on, a write with at least one byte enable set and without the privileged tag-set combination clears the tag of the addressed word. This holds for privileged ordinary writes as well.
- R4: A write with all byte enables at 0 changes neither the data nor the tag of the addressed word.
- R5: With the mode on, a write with reqPriv=1 and reqTagSet=1 writes the enabled bytes and sets the word's tag to 1, even when no byte enable is set.
- R6: A tag-set command with reqPriv=0 is treated as an ordinary write: it cannot set the tag and, with any byte enable set, it clears it.
- R7: A read never changes a tag or a data word.
- R8: With the mode off, writes update data only, tags keep their stored values, tag-set commands set nothing, and reads return rdTag=0 and rdGroupOk=0. After the mode returns to on, the retained tags read back unchanged.
- R9: The mode input is registered on every clock. A request uses the mode value registered at the previous clock edge, which is on (1) directly after reset.
- R10: With the mode on, rdGroupOk is the AND of the tags of the GROUP_WORDS consecutive words in the aligned group (address with its low log2(GROUP_WORDS) bits zeroed) that contains the read address. The default is GROUP_WORDS=4.
- R11: Byte enable bit i governs data bits 8*i+7 down to 8*i. Lanes whose enable is 0 keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tagsActive | input | 1 | Tags mode request, registered every clock |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | 32 | Write data |
| reqByteEn | input | 4 | Per-byte write enables |
| reqPriv | input | 1 | Request comes from privileged software |
| reqTagSet | input | 1 | Tag-set command qualifier for a write |
| rdValid | output | 1 | Read result valid |
| rdData | output | 32 | Read data word |
| rdTag | output | 1 | Tag of the read word (0 when mode is off) |
| rdGroupOk | output | 1 | AND of the tags of the read word's group (0 when mode is off) |

## Verification
The properties assume that the request inputs and the mode input are known, never X, in every cycle after reset. They also assume that a read following a write to the same word sees that write's tag effect at once, which holds because there is one request port and no write buffer. The stimulus changes all inputs on the falling clock edge only. It keeps random addresses inside a small window so that writes, tag-sets and reads often hit the same word and the same group. It switches the mode off only in short stretches, so that tags survive across those stretches and are checked afterwards.

// File: rtl/tgm_pkg.sv
package tgm_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  // Strobes handed from the request decoder to the storage datapath.
  typedef struct packed {
    logic             rd;      // capture a read result next edge
    logic             wr;      // update data lanes
    logic [LANES-1:0] lanes;   // which byte lanes to update
    logic             tagSet;  // raise the addressed tag
    logic             tagClr;  // drop the addressed tag
    logic             tagsOn;  // registered mode in force this cycle
  } tgmStrobes_t;

endpackage

// File: rtl/tgm_ctrl.sv
module tgm_ctrl
  import tgm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tagsActive,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqByteEn,
  input  logic             reqPriv,
  input  logic             reqTagSet,
  output tgmStrobes_t      strobes,
  output logic             tagsOnQ
);

  logic wrReq;
  logic anyLane;
  logic privSet;

  // Mode register: defaults to tagged operation out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tagsOnQ <= 1'b1;
    else       tagsOnQ <= tagsActive;
  end

  always_comb begin
    wrReq   = reqValid & reqWrite;
    anyLane = |reqByteEn;
    privSet = reqPriv & reqTagSet;

    strobes        = '0;
    strobes.rd     = reqValid & ~reqWrite;
    strobes.wr     = wrReq & anyLane;
    strobes.lanes  = reqByteEn;
    strobes.tagsOn = tagsOnQ;
    // The explicit privileged command is the only path to a set tag.
    strobes.tagSet = wrReq & tagsOnQ & privSet;
    // Any other modifying write, privileged or not, invalidates the word.
    strobes.tagClr = wrReq & tagsOnQ & anyLane & ~privSet;
  end

endmodule

// File: rtl/tgm_datapath.sv
module tgm_datapath
  import tgm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned GROUP_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tgmStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              rdTag,
  output logic              rdGroupOk
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned GRP_LG = $clog2(GROUP_WORDS);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DEPTH-1:0]  tagMem;
  logic [ADDR_W-1:0] groupBase;
  logic              groupAll;
  logic [DATA_W-1:0] mergedWord;

  // Byte-lane merge of new data into the current word.
  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      assign mergedWord[ln*8 +: 8] = strobes.lanes[ln] ? wdata[ln*8 +: 8]
                                                        : dataMem[addr][ln*8 +: 8];
    end
  endgenerate

  // Aligned group containing the addressed word.
  always_comb begin
    groupBase = addr;
    if (GRP_LG > 0) groupBase[GRP_LG-1:0] = '0;
    groupAll = 1'b1;
    for (int k = 0; k < GROUP_WORDS; k++) begin
      groupAll = groupAll & tagMem[groupBase | ADDR_W'(k)];
    end
  end

  // Data storage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) dataMem[w] <= '0;
    end else if (strobes.wr) begin
      dataMem[addr] <= mergedWord;
    end
  end

  // Tag storage, kept apart from the data lanes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagMem <= '0;
    end else if (strobes.tagSet) begin
      tagMem[addr] <= 1'b1;
    end else if (strobes.tagClr) begin
      tagMem[addr] <= 1'b0;
    end
  end

  // Read result registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      rdData    <= '0;
      rdTag     <= 1'b0;
      rdGroupOk <= 1'b0;
    end else begin
      rdValid <= strobes.rd;
      if (strobes.rd) begin
        rdData    <= dataMem[addr];
        rdTag     <= tagMem[addr] & strobes.tagsOn;
        rdGroupOk <= groupAll & strobes.tagsOn;
      end
    end
  end

endmodule

// File: rtl/tag_guard_mem.sv
module tag_guard_mem
  import tgm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned GROUP_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tagsActive,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [3:0]        reqByteEn,
  input  logic              reqPriv,
  input  logic              reqTagSet,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              rdTag,
  output logic              rdGroupOk
);

  tgmStrobes_t strobes;
  logic        tagsOnQ;

  tgm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tagsActive (tagsActive),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqByteEn  (reqByteEn),
    .reqPriv    (reqPriv),
    .reqTagSet  (reqTagSet),
    .strobes    (strobes),
    .tagsOnQ    (tagsOnQ)
  );

  tgm_datapath #(
    .ADDR_W      (ADDR_W),
    .GROUP_WORDS (GROUP_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addr      (reqAddr),
    .wdata     (reqWdata),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .rdTag     (rdTag),
    .rdGroupOk (rdGroupOk)
  );

endmodule

// File: rtl/tgm_checker.sv
module tgm_checker #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              tagsActive,
  input logic              tagsOnQ,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [3:0]        reqByteEn,
  input logic              reqPriv,
  input logic              reqTagSet,
  input logic              rdValid,
  input logic              rdTag,
  input logic              rdGroupOk
);

  logic              isRd;
  logic              isWr;
  logic              lastClr;
  logic              lastSet;
  logic [ADDR_W-1:0] lastAddr;

  assign isRd = reqValid & ~reqWrite;
  assign isWr = reqValid & reqWrite;

  // Remember the tag effect of the previous cycle's write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastClr  <= 1'b0;
      lastSet  <= 1'b0;
      lastAddr <= '0;
    end else begin
      lastSet  <= isWr & tagsOnQ & reqPriv & reqTagSet;
      lastClr  <= isWr & tagsOnQ & (|reqByteEn) & ~(reqPriv & reqTagSet);
      lastAddr <= reqAddr;
    end
  end

  // R1: read result one clock after a read request
  a_r1_read_returns: assert property (@(posedge clk) disable iff (!rstN)
    isRd |=> rdValid);

  // R1: no result without a read request
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !isRd |=> !rdValid);

  // R8: mode off hides tags and group flag
  a_r8_mode_off_hides: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && !tagsOnQ) |=> (!rdTag && !rdGroupOk));

  // R10: a complete group implies the word's own tag
  a_r10_group_implies_tag: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdGroupOk) |-> rdTag);

  // R9: mode register follows the input with one clock of delay
  a_r9_mode_tracks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (tagsOnQ == $past(tagsActive)));

  // R3: a clearing write is seen by a read of the same word right after
  a_r3_clear_visible: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && tagsOnQ && lastClr && reqAddr == lastAddr) |=> !rdTag);

  // R5: a privileged tag-set is seen by a read of the same word right after
  a_r5_set_visible: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && tagsOnQ && lastSet && reqAddr == lastAddr) |=> rdTag);

endmodule

bind tag_guard_mem tgm_checker #(.ADDR_W(ADDR_W)) u_tgm_checker (
  .clk        (clk),
  .rstN       (rstN),
  .tagsActive (tagsActive),
  .tagsOnQ    (tagsOnQ),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqAddr    (reqAddr),
  .reqByteEn  (reqByteEn),
  .reqPriv    (reqPriv),
  .reqTagSet  (reqTagSet),
  .rdValid    (rdValid),
  .rdTag      (rdTag),
  .rdGroupOk  (rdGroupOk)
);

// File: tb/test_tag_guard_mem.sv
`timescale 1ns/1ps
module test_tag_guard_mem;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int GW    = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tagsActive = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic [3:0]    reqByteEn = '0;
  logic          reqPriv = 1'b0;
  logic          reqTagSet = 1'b0;
  logic          rdValid;
  logic [31:0]   rdData;
  logic          rdTag;
  logic          rdGroupOk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tag_guard_mem #(.ADDR_W(AW), .GROUP_WORDS(GW)) i_tag_guard_mem (
    .clk(clk), .rstN(rstN), .tagsActive(tagsActive),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqByteEn(reqByteEn), .reqPriv(reqPriv),
    .reqTagSet(reqTagSet), .rdValid(rdValid), .rdData(rdData),
    .rdTag(rdTag), .rdGroupOk(rdGroupOk)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] refData [DEPTH];
  bit          refTag  [DEPTH];
  bit          refMode;
  bit          expValid;
  logic [31:0] expData;
  bit          expTag;
  bit          expGrp;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        refData[i] = '0;
        refTag[i]  = 1'b0;
      end
      refMode  = 1'b1;
      expValid = 1'b0;
      expData  = '0;
      expTag   = 1'b0;
      expGrp   = 1'b0;
    end else begin
      expValid = reqValid && !reqWrite;
      if (expValid) begin
        int base;
        bit g;
        base = (int'(reqAddr) / GW) * GW;
        g = 1'b1;
        for (int k = 0; k < GW; k++) g = g & refTag[base + k];
        expData = refData[reqAddr];
        expTag  = refTag[reqAddr] & refMode;
        expGrp  = g & refMode;
      end
      if (reqValid && reqWrite) begin
        for (int b = 0; b < 4; b++)
          if (reqByteEn[b]) refData[reqAddr][b*8 +: 8] = reqWdata[b*8 +: 8];
        if (refMode) begin
          if (reqPriv && reqTagSet)  refTag[reqAddr] = 1'b1;
          else if (reqByteEn != 0)   refTag[reqAddr] = 1'b0;
        end
      end
      refMode = tagsActive;
    end
  end

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(rdValid == expValid, "R1", "rdValid", 32'(rdValid), 32'(expValid));
      if (expValid) begin
        check(rdData == expData, "R11", "rdData", rdData, expData);
        check(rdTag == expTag, "R7", "rdTag", 32'(rdTag), 32'(expTag));
        check(rdGroupOk == expGrp, "R10", "rdGroupOk", 32'(rdGroupOk), 32'(expGrp));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    reqValid = 1'b0; reqWrite = 1'b0; reqPriv = 1'b0;
    reqTagSet = 1'b0; reqByteEn = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be,
                    input bit priv, input bit tset);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(a);
    reqWdata = d; reqByteEn = be; reqPriv = priv; reqTagSet = tset;
    @(negedge clk);
    idle();
  endtask

  task automatic rdChk(input int a, input logic [31:0] d, input bit t,
                       input bit g, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = AW'(a);
    @(negedge clk);
    check(rdValid == 1'b1, req, "directed rdValid", 32'(rdValid), 32'd1);
    check(rdData == d, req, "directed rdData", rdData, d);
    check(rdTag == t, req, "directed rdTag", 32'(rdTag), 32'(t));
    check(rdGroupOk == g, req, "directed rdGroupOk", 32'(rdGroupOk), 32'(g));
    idle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- directed and random sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state visible at the ports
    check(rdValid == 1'b0, "R2", "rdValid in reset", 32'(rdValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdValid == 1'b0, "R2", "rdValid after reset", 32'(rdValid), 32'd0);
    rdChk(5, 32'h0, 1'b0, 1'b0, "R2");

    // R5: privileged tag-set of the group 8..11
    for (int a = 8; a < 12; a++) wr(a, 32'hA000_0000 + a, 4'hF, 1'b1, 1'b1);
    rdChk(9, 32'hA000_0009, 1'b1, 1'b1, "R5");
    rdChk(10, 32'hA000_000A, 1'b1, 1'b1, "R10");
    // R7: repeated reads leave the tag alone
    rdChk(9, 32'hA000_0009, 1'b1, 1'b1, "R7");

    // R3 / R11: user write of lane 1 only
    wr(9, 32'h1234_5678, 4'b0010, 1'b0, 1'b0);
    rdChk(9, 32'hA000_5609, 1'b0, 1'b0, "R3");
    rdChk(10, 32'hA000_000A, 1'b1, 1'b0, "R10");

    // R4: no lanes enabled
    wr(10, 32'hFFFF_FFFF, 4'b0000, 1'b0, 1'b0);
    rdChk(10, 32'hA000_000A, 1'b1, 1'b0, "R4");

    // R3: privileged ordinary write still clears
    wr(11, 32'hCAFE_0011, 4'hF, 1'b1, 1'b0);
    rdChk(11, 32'hCAFE_0011, 1'b0, 1'b0, "R3");

    // R6: tag-set command without privilege
    wr(8, 32'h0000_00BB, 4'b0001, 1'b0, 1'b1);
    rdChk(8, 32'hA000_00BB, 1'b0, 1'b0, "R6");

    // R5: tag-set with no lanes still raises the tag
    wr(8, 32'hFFFF_FFFF, 4'b0000, 1'b1, 1'b1);
    rdChk(8, 32'hA000_00BB, 1'b1, 1'b0, "R5");

    // R8: mode off stretch
    for (int a = 12; a < 16; a++) wr(a, 32'hB000_0000 + a, 4'hF, 1'b1, 1'b1);
    @(negedge clk); tagsActive = 1'b0;
    @(negedge clk);
    rdChk(12, 32'hB000_000C, 1'b0, 1'b0, "R8");
    wr(13, 32'h0D0D_0D0D, 4'hF, 1'b0, 1'b0);
    wr(20, 32'h2020_2020, 4'hF, 1'b1, 1'b1);
    rdChk(13, 32'h0D0D_0D0D, 1'b0, 1'b0, "R8");
    @(negedge clk); tagsActive = 1'b1;
    @(negedge clk);
    rdChk(13, 32'h0D0D_0D0D, 1'b1, 1'b1, "R8");
    rdChk(20, 32'h2020_2020, 1'b0, 1'b0, "R8");

    // R9: mode change takes effect one clock later
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = AW'(24);
    reqWdata = 32'h2424_2424; reqByteEn = 4'hF; reqPriv = 1'b1; reqTagSet = 1'b1;
    tagsActive = 1'b0;
    @(negedge clk);
    idle();
    tagsActive = 1'b1;
    reqValid = 1'b1; reqAddr = AW'(24);
    @(negedge clk);
    check(rdTag == 1'b0, "R9", "tag while registered mode off", 32'(rdTag), 32'd0);
    idle();
    rdChk(24, 32'h2424_2424, 1'b1, 1'b0, "R9");

    // Random traffic on a narrow window, compared every clock.
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      reqValid  = ($urandom_range(0, 3) != 0);
      reqWrite  = $urandom_range(0, 1);
      reqAddr   = AW'($urandom_range(0, 15));
      reqWdata  = $urandom;
      reqByteEn = 4'($urandom_range(0, 15));
      reqPriv   = $urandom_range(0, 1);
      reqTagSet = ($urandom_range(0, 2) == 0);
      tagsActive = ($urandom_range(0, 7) != 0);
    end
    @(negedge clk);
    idle();
    tagsActive = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule